// File: doc/BRIEF.md
# VGA Sync and Pixel Position Generator

This block derives the raster timing for a 640 by 480 display refreshed at roughly 60 Hz from a 25 MHz pixel clock. It has two free-running counters. The horizontal counter steps on every pixel clock. The vertical counter steps once per line, and it is enabled by the event that starts each horizontal sync pulse.

Each sync output comes from a set/reset flop. A zero detect on the flop's counter sets it, and a pulse-width detect on the same counter clears it. The flop state is inverted at the pins, so both syncs are active-low.

Alongside the syncs, the block presents a registered display-active flag and the current column and row. External logic uses these to address video memory and to blank colour. Every output is registered, and together they describe the counter position of the previous clock. After reset is released, the first clock edge starts the first frame at line 0, count 0.

Top module: `vga_sync_gen`

## Requirements
- R1: A line lasts 800 clocks, so consecutive falling edges of `hsync_no` are exactly 800 clocks apart.
- R2: Within a line, `hsync_no` is low for the first 96 clocks and high for the other 704.
- R3: A frame lasts 521 lines (416,800 clocks). `vsync_no` is low for lines 0 and 1 of the frame (1,600 clocks) and high on the other 519 lines.
- R4: The vertical position advances only at line starts, so every falling edge of `vsync_no` happens in the same clock as a falling edge of `hsync_no`.
- R5: `active_o` is high only when both windows hold. Horizontally that is line clocks 144 to 783: after the 96-clock sync and a 48-clock back porch, and before a 16-clock front porch. Vertically that is frame lines 31 to 510: after the 2-line sync and a 29-line back porch, and before a 10-line front porch. `active_o` is never high while either sync is low.
- R6: While `active_o` is high, `col_o` equals the line clock minus 144 (0 to 639), rising by one each clock, and `row_o` equals the frame line minus 31 (0 to 479). While `active_o` is low, both read 0.
- R7: While `rst_ni` is low, `hsync_no` and `vsync_no` are 1, `active_o` is 0, and `col_o` and `row_o` are 0. The first clock edge after release drives both syncs low, marking line 0, clock 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| active_o | output | 1 | High while the position is inside the visible window |
| col_o | output | COL_W | Visible column, 0 when not active |
| row_o | output | ROW_W | Visible row, 0 when not active |

## Verification
A reference model in the bench predicts every output clock by clock from the clock count since reset, and it does so for two instances. The full-size instance runs past the vertical sync and into the visible rows, which separates the 2-line vertical pulse, the 29-line back porch offset and the 144-clock column offset from nearby wrong values. A scaled-down instance, with short porches and syncs, runs through hundreds of whole frames, which exposes wrap errors at the end of a line and the end of a frame. A reset asserted in mid-frame then shows whether the counters restart from zero and whether sync begins on the first edge after release. Separate measurements of the spacing between sync edges, and of whether vertical sync coincides with horizontal sync, tell a wrong line length apart from a wrong pulse width.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;
  // default 640x480 raster, 25 MHz pixel clock
  localparam int unsigned H_VIS_DEF  = 640;
  localparam int unsigned H_FP_DEF   = 16;
  localparam int unsigned H_SYNC_DEF = 96;
  localparam int unsigned H_BP_DEF   = 48;
  localparam int unsigned V_VIS_DEF  = 480;
  localparam int unsigned V_FP_DEF   = 10;
  localparam int unsigned V_SYNC_DEF = 2;
  localparam int unsigned V_BP_DEF   = 29;
  localparam int unsigned COL_W_DEF  = 10;
  localparam int unsigned ROW_W_DEF  = 9;

  function automatic int unsigned axis_total(int unsigned vis, int unsigned fp,
                                             int unsigned sync, int unsigned bp);
    return vis + fp + sync + bp;
  endfunction
endpackage

// File: rtl/vga_mod_counter.sv
module vga_mod_counter #(
  parameter int unsigned MAX = 800,
  parameter int unsigned W   = $clog2(MAX)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == W'(MAX - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/vga_sr_flop.sv
module vga_sr_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  assign q_o = q_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (en_i) begin
      if (set_i)      q_q <= 1'b1;
      else if (clr_i) q_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vga_window.sv
module vga_window #(
  parameter int unsigned START = 144,
  parameter int unsigned LEN   = 640,
  parameter int unsigned CW    = 10,
  parameter int unsigned OW    = 10
) (
  input  logic [CW-1:0] cnt_i,
  output logic          in_o,
  output logic [OW-1:0] off_o
);
  localparam logic [CW:0] LO = (CW+1)'(START);
  localparam logic [CW:0] HI = (CW+1)'(START + LEN);

  logic [CW-1:0] diff;

  assign in_o  = ({1'b0, cnt_i} >= LO) && ({1'b0, cnt_i} < HI);
  assign diff  = cnt_i - CW'(START);
  assign off_o = in_o ? OW'(diff) : '0;
endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
  import vga_sync_pkg::*;
#(
  parameter int unsigned H_VIS  = H_VIS_DEF,
  parameter int unsigned H_FP   = H_FP_DEF,
  parameter int unsigned H_SYNC = H_SYNC_DEF,
  parameter int unsigned H_BP   = H_BP_DEF,
  parameter int unsigned V_VIS  = V_VIS_DEF,
  parameter int unsigned V_FP   = V_FP_DEF,
  parameter int unsigned V_SYNC = V_SYNC_DEF,
  parameter int unsigned V_BP   = V_BP_DEF,
  parameter int unsigned COL_W  = COL_W_DEF,
  parameter int unsigned ROW_W  = ROW_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             hsync_no,
  output logic             vsync_no,
  output logic             active_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned H_TOTAL = axis_total(H_VIS, H_FP, H_SYNC, H_BP);
  localparam int unsigned V_TOTAL = axis_total(V_VIS, V_FP, V_SYNC, V_BP);
  localparam int unsigned HCW     = $clog2(H_TOTAL);
  localparam int unsigned VCW     = $clog2(V_TOTAL);

  logic [HCW-1:0]   hcnt;
  logic [VCW-1:0]   vcnt;
  logic             h_last, v_last;
  logic             line_start;
  logic             hs_q, vs_q;
  logic             h_in, v_in;
  logic [COL_W-1:0] h_off;
  logic [ROW_W-1:0] v_off;
  logic             active_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  vga_mod_counter #(.MAX(H_TOTAL), .W(HCW)) u_hcnt (
    .clk_i, .rst_ni, .en_i(1'b1), .cnt_o(hcnt), .last_o(h_last)
  );

  // line advance on horizontal wrap, the same event that sets hsync
  vga_mod_counter #(.MAX(V_TOTAL), .W(VCW)) u_vcnt (
    .clk_i, .rst_ni, .en_i(h_last), .cnt_o(vcnt), .last_o(v_last)
  );

  assign line_start = (hcnt == '0);

  vga_sr_flop u_hs (
    .clk_i, .rst_ni, .en_i(1'b1),
    .set_i(line_start), .clr_i(hcnt == HCW'(H_SYNC)), .q_o(hs_q)
  );

  vga_sr_flop u_vs (
    .clk_i, .rst_ni, .en_i(line_start),
    .set_i(vcnt == '0), .clr_i(vcnt == VCW'(V_SYNC)), .q_o(vs_q)
  );

  vga_window #(.START(H_SYNC + H_BP), .LEN(H_VIS), .CW(HCW), .OW(COL_W)) u_hwin (
    .cnt_i(hcnt), .in_o(h_in), .off_o(h_off)
  );

  vga_window #(.START(V_SYNC + V_BP), .LEN(V_VIS), .CW(VCW), .OW(ROW_W)) u_vwin (
    .cnt_i(vcnt), .in_o(v_in), .off_o(v_off)
  );

  // registered to line up with the sync flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
    end else begin
      active_q <= h_in & v_in;
      col_q    <= (h_in & v_in) ? h_off : '0;
      row_q    <= (h_in & v_in) ? v_off : '0;
    end
  end

  assign hsync_no = ~hs_q;
  assign vsync_no = ~vs_q;
  assign active_o = active_q;
  assign col_o    = col_q;
  assign row_o    = row_q;

  logic unused_v_last;
  assign unused_v_last = v_last;
endmodule

// File: rtl/vga_sync_chk.sv
module vga_sync_chk #(
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned H_SYNC  = 96,
  parameter int unsigned COL_W   = 10,
  parameter int unsigned ROW_W   = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsync_no,
  input logic             vsync_no,
  input logic             active_o,
  input logic [COL_W-1:0] col_o,
  input logic [ROW_W-1:0] row_o
);
  logic        hs_prev_q, vs_prev_q, seen_q;
  logic [31:0] since_q, low_q;
  logic        h_fell, v_fell;

  assign h_fell = hs_prev_q & ~hsync_no;
  assign v_fell = vs_prev_q & ~vsync_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_prev_q <= 1'b1;
      vs_prev_q <= 1'b1;
      seen_q    <= 1'b0;
      since_q   <= '0;
      low_q     <= '0;
    end else begin
      hs_prev_q <= hsync_no;
      vs_prev_q <= vsync_no;
      if (h_fell) seen_q <= 1'b1;
      since_q   <= h_fell ? 32'd1 : since_q + 32'd1;
      low_q     <= hsync_no ? '0 : low_q + 32'd1;
    end
  end

  p_line_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_fell && seen_q |-> since_q == H_TOTAL);

  p_hs_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_no && !hs_prev_q |-> low_q == H_SYNC);

  p_vs_on_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_fell |-> h_fell);

  p_blank_in_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> hsync_no && vsync_no);

  p_idle_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> col_o == '0 && row_o == '0);

  p_col_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && $past(active_o) |-> col_o == COL_W'($past(col_o) + 1'b1) && row_o == $past(row_o));

  p_reset_vals_r7: assert property (@(posedge clk_i)
    !rst_ni |-> hsync_no && vsync_no && !active_o);
endmodule

bind vga_sync_gen vga_sync_chk #(
  .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_no(hsync_no), .vsync_no(vsync_no),
  .active_o(active_o), .col_o(col_o), .row_o(row_o)
);

// File: tb/vga_sync_gen_tb_top.sv
module vga_sync_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni;
  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic       hs_n;
    logic       vs_n;
    logic       act;
    logic [9:0] col;
    logic [8:0] row;
  } item_t;

  logic       b_hs, b_vs, b_act, s_hs, s_vs, s_act;
  logic [9:0] b_col, s_col;
  logic [8:0] b_row, s_row;

  vga_sync_gen dut_i (
    .clk_i, .rst_ni, .hsync_no(b_hs), .vsync_no(b_vs),
    .active_o(b_act), .col_o(b_col), .row_o(b_row)
  );

  // scaled raster: 15 clocks per line, 9 lines per frame
  vga_sync_gen #(
    .H_VIS(8), .H_FP(2), .H_SYNC(3), .H_BP(2),
    .V_VIS(4), .V_FP(1), .V_SYNC(2), .V_BP(2)
  ) dut_s (
    .clk_i, .rst_ni, .hsync_no(s_hs), .vsync_no(s_vs),
    .active_o(s_act), .col_o(s_col), .row_o(s_row)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  item_t q_big[$], q_small[$];
  int    n_big = 0, n_small = 0;

  function automatic item_t model(int n, int hv, int hf, int hsy, int hb,
                                  int vv, int vf, int vsy, int vb);
    item_t it;
    int ht = hv + hf + hsy + hb;
    int vt = vv + vf + vsy + vb;
    int h  = n % ht;
    int v  = (n / ht) % vt;
    it.hs_n = !(h < hsy);
    it.vs_n = !(v < vsy);
    it.act  = (h >= hsy + hb) && (h < hsy + hb + hv) && (v >= vsy + vb) && (v < vsy + vb + vv);
    it.col  = it.act ? 10'(h - hsy - hb) : 10'd0;
    it.row  = it.act ? 9'(v - vsy - vb) : 9'd0;
    return it;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive_expected();
    if (rst_ni) begin
      q_big.push_back(model(n_big, 640, 16, 96, 48, 480, 10, 2, 29));
      q_small.push_back(model(n_small, 8, 2, 3, 2, 4, 1, 2, 2));
      n_big++;
      n_small++;
    end
  endtask

  task automatic compare(item_t e, logic hs, logic vs, logic act,
                         logic [9:0] col, logic [8:0] row, bit first, string who);
    chk(hs == e.hs_n, first ? "R7" : "R2", {who, " hsync_no"}, hs, e.hs_n);
    chk(vs == e.vs_n, first ? "R7" : "R3", {who, " vsync_no"}, vs, e.vs_n);
    chk(act == e.act, "R5", {who, " active_o"}, act, e.act);
    chk(col == e.col, "R6", {who, " col_o"}, col, e.col);
    chk(row == e.row, "R6", {who, " row_o"}, row, e.row);
  endtask

  always @(posedge clk_i) drive_expected();

  // monitor: edge trackers for line and frame spacing
  bit b_hs_p = 1, b_vs_p = 1, b_seen = 0, s_vs_p = 1, s_seen = 0;
  int b_since = 0, s_since = 0;
  int b_idx = 0, s_idx = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(b_hs && b_vs && !b_act && b_col == 0 && b_row == 0, "R7", "big reset outputs",
          {b_hs, b_vs, b_act}, 3'b110);
      chk(s_hs && s_vs && !s_act && s_col == 0 && s_row == 0, "R7", "small reset outputs",
          {s_hs, s_vs, s_act}, 3'b110);
      q_big.delete();
      q_small.delete();
      n_big = 0; n_small = 0; b_idx = 0; s_idx = 0;
      b_hs_p = 1; b_vs_p = 1; b_seen = 0; s_vs_p = 1; s_seen = 0;
      b_since = 0; s_since = 0;
    end else begin
      if (q_big.size() > 0) begin
        compare(q_big.pop_front(), b_hs, b_vs, b_act, b_col, b_row, b_idx == 0, "big");
        b_idx++;
      end
      if (q_small.size() > 0) begin
        compare(q_small.pop_front(), s_hs, s_vs, s_act, s_col, s_row, s_idx == 0, "small");
        s_idx++;
      end
      // R1 line spacing on the full-size instance
      if (b_hs_p && !b_hs) begin
        if (b_seen) chk(b_since == 800, "R1", "clocks between hsync falls", b_since, 800);
        b_seen  = 1;
        b_since = 1;
      end else b_since++;
      // R4 vsync onset coincides with hsync onset
      if (b_vs_p && !b_vs) chk(b_hs_p && !b_hs, "R4", "hsync fall with vsync fall", b_hs, 0);
      // R3 frame spacing on the scaled instance
      if (s_vs_p && !s_vs) begin
        if (s_seen) chk(s_since == 135, "R3", "clocks between vsync falls", s_since, 135);
        s_seen  = 1;
        s_since = 1;
      end else s_since++;
      b_hs_p = b_hs;
      b_vs_p = b_vs;
      s_vs_p = s_vs;
    end
  end

  initial begin
    rst_ni = 1'b1;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    #2 rst_ni = 1'b1;
    repeat (40 * 800 + 10) @(negedge clk_i);
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    #2 rst_ni = 1'b1;
    repeat (2000) @(negedge clk_i);
    #1;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule